// File: doc/BRIEF.md
# Flash Unlock Command Decoder

This block turns the stream of write cycles that a host issues to a flash array into single-cycle operation requests for the controller that carries them out. Each write reaches the block as a one-cycle strobe with a 16-bit address and the low data byte. Operations that change the array are guarded by a fixed unlock preamble. The preamble is two writes to fixed addresses with fixed data. After it comes a command byte, and the destructive operations need a second preamble and a confirm byte.

The block also takes the execution state of the controller as an input. While an erase is pending or running, or while it is suspended, only a narrow set of writes is honoured. The rest are ignored or abort the sequence. A registered read-mode output tells the read path whether to return array data, identification data, or status. Any improper write returns the decoder to read-array mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset `read_mode` is 0 (array), no request is asserted, and any partial sequence is discarded: a later second preamble write followed by a command does not produce a request.
- R2: The preamble is data AAh at address 555h and then data 55h at address AAAh. Only address bits 11..0 are compared, so bits 15..12 have no effect.
- R3: On the write after the preamble, at address 555h: F0h requests read-array, 90h requests auto select and sets `read_mode` to 1, A0h arms a program, and 80h arms the erase/protect setup. The same data at any other address aborts.
- R4: The write after an armed program, with any address and data, issues `req_program` carrying that address and data, and sets `read_mode` to 2 (status).
- R5: After setup 80h, a second preamble is required. The next write then gives 10h at 555h for chip erase, 30h at any address for block erase, 40h at any address for protect, or 60h at exactly 9041h (all 16 bits compared) for unprotect. Each sets `read_mode` to 2.
- R6: With the controller idle (`exec_state` 0), any write of F0h that does not complete another sequence issues `req_read_array` and sets `read_mode` to 0. This holds even in the middle of a sequence.
- R7: With the controller idle, a write that does not fit the current sequence step issues no request and sets `read_mode` to 0. If that write is itself AAh at 555h, it starts a new sequence. A bare B0h or 30h is such an improper write.
- R8: While the erase window is open (`exec_state` 1), 30h at any address issues `req_block_erase` with that address, B0h issues `req_suspend`, F0h issues `req_read_array`, and all other writes are ignored with no sequence progress.
- R9: While erasing (`exec_state` 2), only B0h (suspend) and F0h (read-array) are honoured. All other writes, including 30h and preamble writes, are ignored and leave `read_mode` unchanged.
- R10: While suspended (`exec_state` 3), a bare 30h issues `req_resume` and sets `read_mode` to 2. The preamble plus A0h plus a data write issues a program. Any other third-cycle command aborts, and a bare F0h is ignored.
- R11: Requests are registered pulses. They appear in the clock cycle after the strobe, last one cycle, and at most one is asserted at a time. `req_addr` and `req_data` hold the address and data of the last request until the next one.
- R12: `read_mode` encodes 0 as array, 1 as auto select and 2 as status. Suspend and read-array set it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Low data byte of the write |
| exec_state | input | 2 | Controller state: 0 idle, 1 erase window, 2 erasing, 3 suspended |
| req_read_array | output | 1 | Return-to-read-array request pulse |
| req_autoselect | output | 1 | Auto select request pulse |
| req_program | output | 1 | Program request pulse |
| req_block_erase | output | 1 | Block erase (or add block) request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_protect | output | 1 | Block protect request pulse |
| req_unprotect | output | 1 | Unprotect request pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| req_addr | output | 16 | Address captured with the last request |
| req_data | output | 8 | Data captured with the last request |
| read_mode | output | 2 | Read source select: 0 array, 1 auto select, 2 status |

## Verification
A sequence state that is wrong on the inside stays hidden until the write that should finish or break the sequence. At that point it shows in the very next cycle, either as a missing or extra request pulse or as a `read_mode` that did not return to 0. The stimulus therefore ends every sequence with a closing write, and several sequences are broken on purpose with a wrong address, wrong data, or a restarting AAh. Gating by execution state is checked in the same way, by writes that must be ignored and whose effect would show in `read_mode` or in a stray pulse one cycle later.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CMD_W   = 8;
    localparam int KEY_W   = 12;
    localparam int NUM_REQ = 9;

    localparam logic [KEY_W-1:0] KEY_ADDR_A = 12'h555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 12'hAAA;
    localparam logic [15:0]      UNPROT_ADDR = 16'h9041;

    localparam logic [CMD_W-1:0] KEY_DATA_A = 8'hAA;
    localparam logic [CMD_W-1:0] KEY_DATA_B = 8'h55;
    localparam logic [CMD_W-1:0] OP_RESET   = 8'hF0;
    localparam logic [CMD_W-1:0] OP_ASEL    = 8'h90;
    localparam logic [CMD_W-1:0] OP_PROG    = 8'hA0;
    localparam logic [CMD_W-1:0] OP_SETUP   = 8'h80;
    localparam logic [CMD_W-1:0] OP_CHIP    = 8'h10;
    localparam logic [CMD_W-1:0] OP_BLOCK   = 8'h30;
    localparam logic [CMD_W-1:0] OP_LOCK    = 8'h40;
    localparam logic [CMD_W-1:0] OP_UNLOCK  = 8'h60;
    localparam logic [CMD_W-1:0] OP_PAUSE   = 8'hB0;

    typedef enum logic [1:0] {
        EX_IDLE      = 2'd0,
        EX_WINDOW    = 2'd1,
        EX_ERASING   = 2'd2,
        EX_SUSPENDED = 2'd3
    } exec_e;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_ASEL   = 2'd1,
        MODE_STATUS = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PROG,
        SQ_SETUP,
        SQ_KEY4,
        SQ_KEY5
    } seq_e;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_ABORT,
        ACT_RESET,
        ACT_ASEL,
        ACT_PROG,
        ACT_BERASE,
        ACT_CERASE,
        ACT_PROT,
        ACT_UNPROT,
        ACT_SUSP,
        ACT_RESUME
    } act_e;

    // Classification of a single write, produced by the match unit.
    typedef struct packed {
        logic key1;
        logic key2;
        logic at_cmd;
        logic at_unprot;
        logic op_reset;
        logic op_asel;
        logic op_prog;
        logic op_setup;
        logic op_chip;
        logic op_block;
        logic op_lock;
        logic op_unlock;
        logic op_pause;
    } wr_class_t;

    typedef struct packed {
        logic rd_array;
        logic asel;
        logic prog;
        logic berase;
        logic cerase;
        logic prot;
        logic unprot;
        logic susp;
        logic resume;
    } req_t;

    function automatic req_t act_to_req(act_e a);
        req_t r;
        r = '0;
        case (a)
            ACT_RESET:  r.rd_array = 1'b1;
            ACT_ASEL:   r.asel     = 1'b1;
            ACT_PROG:   r.prog     = 1'b1;
            ACT_BERASE: r.berase   = 1'b1;
            ACT_CERASE: r.cerase   = 1'b1;
            ACT_PROT:   r.prot     = 1'b1;
            ACT_UNPROT: r.unprot   = 1'b1;
            ACT_SUSP:   r.susp     = 1'b1;
            ACT_RESUME: r.resume   = 1'b1;
            default:    r = '0;
        endcase
        return r;
    endfunction

    function automatic mode_e next_mode(act_e a, mode_e cur);
        mode_e m;
        case (a)
            ACT_ABORT, ACT_RESET, ACT_SUSP: m = MODE_ARRAY;
            ACT_ASEL:                       m = MODE_ASEL;
            ACT_PROG, ACT_BERASE, ACT_CERASE,
            ACT_PROT, ACT_UNPROT, ACT_RESUME: m = MODE_STATUS;
            default:                        m = cur;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cmd_addr_match.sv
module cmd_addr_match
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = CMD_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output wr_class_t         cls
);
    localparam int NUM_OPS = 9;
    localparam logic [DATA_W-1:0] OP_TABLE [NUM_OPS] = '{
        OP_RESET, OP_ASEL, OP_PROG, OP_SETUP, OP_CHIP,
        OP_BLOCK, OP_LOCK, OP_UNLOCK, OP_PAUSE
    };

    logic [NUM_OPS-1:0] op_hit;
    logic               addr_a;
    logic               addr_b;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        assign op_hit[i] = (data == OP_TABLE[i]);
    end

    assign addr_a = (addr[KEY_W-1:0] == KEY_ADDR_A);
    assign addr_b = (addr[KEY_W-1:0] == KEY_ADDR_B);

    always_comb begin
        cls.key1      = addr_a && (data == KEY_DATA_A);
        cls.key2      = addr_b && (data == KEY_DATA_B);
        cls.at_cmd    = addr_a;
        cls.at_unprot = (addr == ADDR_W'(UNPROT_ADDR));
        cls.op_reset  = op_hit[0];
        cls.op_asel   = op_hit[1];
        cls.op_prog   = op_hit[2];
        cls.op_setup  = op_hit[3];
        cls.op_chip   = op_hit[4];
        cls.op_block  = op_hit[5];
        cls.op_lock   = op_hit[6];
        cls.op_unlock = op_hit[7];
        cls.op_pause  = op_hit[8];
    end

endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import flash_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_stb,
    input  wr_class_t cls,
    input  exec_e     exec,
    output act_e      act
);
    seq_e st_q;
    seq_e st_d;
    logic susp_ex;
    seq_e abort_st;
    act_e abort_act;

    always_comb begin
        susp_ex   = (exec == EX_SUSPENDED);
        // A breaking write restarts when it is itself a first preamble cycle.
        abort_st  = cls.key1 ? SQ_KEY1 : SQ_IDLE;
        abort_act = (!susp_ex && cls.op_reset) ? ACT_RESET : ACT_ABORT;
        st_d      = st_q;
        act       = ACT_NONE;
        if (wr_stb) begin
            case (exec)
                EX_WINDOW: begin
                    st_d = SQ_IDLE;
                    if (cls.op_block)      act = ACT_BERASE;
                    else if (cls.op_pause) act = ACT_SUSP;
                    else if (cls.op_reset) act = ACT_RESET;
                end
                EX_ERASING: begin
                    st_d = SQ_IDLE;
                    if (cls.op_pause)      act = ACT_SUSP;
                    else if (cls.op_reset) act = ACT_RESET;
                end
                default: begin
                    case (st_q)
                        SQ_IDLE: begin
                            if (cls.key1)                     st_d = SQ_KEY1;
                            else if (susp_ex && cls.op_block) act = ACT_RESUME;
                            else if (!susp_ex)                act = abort_act;
                        end
                        SQ_KEY1: begin
                            if (cls.key2) st_d = SQ_KEY2;
                            else begin
                                st_d = abort_st;
                                act  = abort_act;
                            end
                        end
                        SQ_KEY2: begin
                            st_d = SQ_IDLE;
                            if (cls.at_cmd && cls.op_prog) begin
                                st_d = SQ_PROG;
                            end else if (!susp_ex && cls.at_cmd && cls.op_reset) begin
                                act = ACT_RESET;
                            end else if (!susp_ex && cls.at_cmd && cls.op_asel) begin
                                act = ACT_ASEL;
                            end else if (!susp_ex && cls.at_cmd && cls.op_setup) begin
                                st_d = SQ_SETUP;
                            end else begin
                                st_d = abort_st;
                                act  = abort_act;
                            end
                        end
                        SQ_PROG: begin
                            st_d = SQ_IDLE;
                            act  = ACT_PROG;
                        end
                        SQ_SETUP: begin
                            if (cls.key1) st_d = SQ_KEY4;
                            else begin
                                st_d = abort_st;
                                act  = abort_act;
                            end
                        end
                        SQ_KEY4: begin
                            if (cls.key2) st_d = SQ_KEY5;
                            else begin
                                st_d = abort_st;
                                act  = abort_act;
                            end
                        end
                        SQ_KEY5: begin
                            st_d = SQ_IDLE;
                            if (cls.at_cmd && cls.op_chip)           act = ACT_CERASE;
                            else if (cls.op_block)                   act = ACT_BERASE;
                            else if (cls.op_lock)                    act = ACT_PROT;
                            else if (cls.at_unprot && cls.op_unlock) act = ACT_UNPROT;
                            else begin
                                st_d = abort_st;
                                act  = abort_act;
                            end
                        end
                        default: begin
                            st_d = SQ_IDLE;
                            act  = ACT_ABORT;
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SQ_IDLE;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/cmd_req_gen.sv
module cmd_req_gen
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = CMD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  act_e              act,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output req_t              req_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output mode_e             mode_q
);
    req_t req_d;
    logic issue;

    always_comb begin
        req_d = act_to_req(act);
        issue = (req_d != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            mode_q <= MODE_ARRAY;
        end else begin
            req_q  <= req_d;
            mode_q <= next_mode(act, mode_q);
            if (issue) begin
                addr_q <= addr;
                data_q <= data;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = CMD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        exec_state,
    output logic              req_read_array,
    output logic              req_autoselect,
    output logic              req_program,
    output logic              req_block_erase,
    output logic              req_chip_erase,
    output logic              req_protect,
    output logic              req_unprotect,
    output logic              req_suspend,
    output logic              req_resume,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [1:0]        read_mode
);
    wr_class_t cls;
    act_e      act;
    req_t      req;
    mode_e     mode;

    cmd_addr_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .addr (wr_addr),
        .data (wr_data),
        .cls  (cls)
    );

    cmd_seq_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_stb),
        .cls    (cls),
        .exec   (exec_e'(exec_state)),
        .act    (act)
    );

    cmd_req_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .addr   (wr_addr),
        .data   (wr_data),
        .req_q  (req),
        .addr_q (req_addr),
        .data_q (req_data),
        .mode_q (mode)
    );

    assign req_read_array  = req.rd_array;
    assign req_autoselect  = req.asel;
    assign req_program     = req.prog;
    assign req_block_erase = req.berase;
    assign req_chip_erase  = req.cerase;
    assign req_protect     = req.prot;
    assign req_unprotect   = req.unprot;
    assign req_suspend     = req.susp;
    assign req_resume      = req.resume;
    assign read_mode       = mode;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic [1:0]        exec_state,
    input logic              req_read_array,
    input logic              req_autoselect,
    input logic              req_program,
    input logic              req_block_erase,
    input logic              req_chip_erase,
    input logic              req_protect,
    input logic              req_unprotect,
    input logic              req_suspend,
    input logic              req_resume,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        read_mode
);
    logic [8:0] reqv;
    assign reqv = {req_read_array, req_autoselect, req_program, req_block_erase,
                   req_chip_erase, req_protect, req_unprotect, req_suspend, req_resume};

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (read_mode == 2'd0 && reqv == '0));

    p_one_req_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reqv));

    p_req_after_stb_r11: assert property (@(posedge clk) disable iff (rst)
        (reqv != '0) |-> $past(wr_stb));

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> (reqv == '0 && $stable(read_mode)));

    p_prog_mode_r4: assert property (@(posedge clk) disable iff (rst)
        req_program |-> read_mode == 2'd2);

    p_six_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (req_chip_erase || req_protect || req_unprotect || req_autoselect)
            |-> $past(exec_state) == 2'd0);

    p_unprot_addr_r5: assert property (@(posedge clk) disable iff (rst)
        req_unprotect |-> req_addr == ADDR_W'(16'h9041));

    p_susp_gate_r9: assert property (@(posedge clk) disable iff (rst)
        req_suspend |-> ($past(exec_state) == 2'd1 || $past(exec_state) == 2'd2));

    p_resume_gate_r10: assert property (@(posedge clk) disable iff (rst)
        req_resume |-> $past(exec_state) == 2'd3);

    p_mode_code_r12: assert property (@(posedge clk) disable iff (rst)
        read_mode != 2'd3);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .wr_stb          (wr_stb),
    .exec_state      (exec_state),
    .req_read_array  (req_read_array),
    .req_autoselect  (req_autoselect),
    .req_program     (req_program),
    .req_block_erase (req_block_erase),
    .req_chip_erase  (req_chip_erase),
    .req_protect     (req_protect),
    .req_unprotect   (req_unprotect),
    .req_suspend     (req_suspend),
    .req_resume      (req_resume),
    .req_addr        (req_addr),
    .read_mode       (read_mode)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 72;

    // Request bit order: rd_array, asel, prog, berase, cerase, prot, unprot, susp, resume
    typedef struct packed {
        logic [1:0]  ex;
        logic [15:0] a;
        logic [7:0]  d;
        logic [8:0]  req;
        logic [1:0]  mode;
        logic [3:0]  tag;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        // R2 / R3 auto select
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd0, 4'd2},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd0, 4'd2},
        '{2'd0, 16'h0555, 8'h90, 9'h080, 2'd1, 4'd3},
        // R7 improper write
        '{2'd0, 16'h1234, 8'h77, 9'h000, 2'd0, 4'd7},
        // R2 upper bits ignored, R4 program
        '{2'd0, 16'hF555, 8'hAA, 9'h000, 2'd0, 4'd2},
        '{2'd0, 16'h3AAA, 8'h55, 9'h000, 2'd0, 4'd2},
        '{2'd0, 16'h0555, 8'hA0, 9'h000, 2'd0, 4'd3},
        '{2'd0, 16'h4321, 8'h5A, 9'h040, 2'd2, 4'd4},
        // R6 bare reset
        '{2'd0, 16'h0000, 8'hF0, 9'h100, 2'd0, 4'd6},
        // R5 chip erase
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd0, 4'd5},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd0, 4'd5},
        '{2'd0, 16'h0555, 8'h80, 9'h000, 2'd0, 4'd5},
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd0, 4'd5},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd0, 4'd5},
        '{2'd0, 16'h0555, 8'h10, 9'h010, 2'd2, 4'd5},
        // R5 block erase
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0555, 8'h80, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h8123, 8'h30, 9'h020, 2'd2, 4'd5},
        // R5 protect
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0555, 8'h80, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h2000, 8'h40, 9'h008, 2'd2, 4'd5},
        // R5 unprotect
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0555, 8'h80, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h9041, 8'h60, 9'h004, 2'd2, 4'd5},
        // R5 unprotect at wrong full address aborts
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0555, 8'h80, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd2, 4'd5},
        '{2'd0, 16'h1041, 8'h60, 9'h000, 2'd0, 4'd5},
        // R7 restart on a first preamble write
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd0, 4'd7},
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd0, 4'd7},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd0, 4'd7},
        '{2'd0, 16'h0555, 8'h90, 9'h080, 2'd1, 4'd7},
        // R6 reset in mid sequence
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd1, 4'd6},
        '{2'd0, 16'h0AAA, 8'hF0, 9'h100, 2'd0, 4'd6},
        // R3 command at wrong address
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd0, 4'd3},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd0, 4'd3},
        '{2'd0, 16'h0555, 8'h90, 9'h080, 2'd1, 4'd3},
        '{2'd0, 16'h0555, 8'hAA, 9'h000, 2'd1, 4'd3},
        '{2'd0, 16'h0AAA, 8'h55, 9'h000, 2'd1, 4'd3},
        '{2'd0, 16'h0556, 8'h90, 9'h000, 2'd0, 4'd3},
        // R8 erase window
        '{2'd1, 16'h4000, 8'h30, 9'h020, 2'd2, 4'd8},
        '{2'd1, 16'h0555, 8'hAA, 9'h000, 2'd2, 4'd8},
        '{2'd1, 16'h0AAA, 8'h55, 9'h000, 2'd2, 4'd8},
        '{2'd1, 16'h0555, 8'hA0, 9'h000, 2'd2, 4'd8},
        // R9 erasing
        '{2'd2, 16'h8000, 8'h30, 9'h000, 2'd2, 4'd9},
        '{2'd2, 16'h0555, 8'hAA, 9'h000, 2'd2, 4'd9},
        '{2'd2, 16'h0000, 8'hB0, 9'h002, 2'd0, 4'd9},
        '{2'd1, 16'h0000, 8'hF0, 9'h100, 2'd0, 4'd8},
        '{2'd1, 16'h0000, 8'hB0, 9'h002, 2'd0, 4'd8},
        '{2'd2, 16'h0000, 8'hF0, 9'h100, 2'd0, 4'd9},
        // R10 suspended
        '{2'd3, 16'h0000, 8'hF0, 9'h000, 2'd0, 4'd10},
        '{2'd3, 16'h0555, 8'hAA, 9'h000, 2'd0, 4'd10},
        '{2'd3, 16'h0AAA, 8'h55, 9'h000, 2'd0, 4'd10},
        '{2'd3, 16'h0555, 8'h90, 9'h000, 2'd0, 4'd10},
        '{2'd3, 16'h0555, 8'hAA, 9'h000, 2'd0, 4'd10},
        '{2'd3, 16'h0AAA, 8'h55, 9'h000, 2'd0, 4'd10},
        '{2'd3, 16'h0555, 8'hA0, 9'h000, 2'd0, 4'd10},
        '{2'd3, 16'h1111, 8'h00, 9'h040, 2'd2, 4'd10},
        '{2'd3, 16'h0000, 8'hF0, 9'h000, 2'd2, 4'd10},
        '{2'd3, 16'h7777, 8'h30, 9'h001, 2'd2, 4'd10},
        // R7 bare suspend while idle is improper
        '{2'd0, 16'h0000, 8'hB0, 9'h000, 2'd0, 4'd7}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  exec_state = '0;
    logic        req_read_array, req_autoselect, req_program, req_block_erase;
    logic        req_chip_erase, req_protect, req_unprotect, req_suspend, req_resume;
    logic [15:0] req_addr;
    logic [7:0]  req_data;
    logic [1:0]  read_mode;
    logic [8:0]  reqv;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder uut (
        .clk             (clk),
        .rst             (rst),
        .wr_stb          (wr_stb),
        .wr_addr         (wr_addr),
        .wr_data         (wr_data),
        .exec_state      (exec_state),
        .req_read_array  (req_read_array),
        .req_autoselect  (req_autoselect),
        .req_program     (req_program),
        .req_block_erase (req_block_erase),
        .req_chip_erase  (req_chip_erase),
        .req_protect     (req_protect),
        .req_unprotect   (req_unprotect),
        .req_suspend     (req_suspend),
        .req_resume      (req_resume),
        .req_addr        (req_addr),
        .req_data        (req_data),
        .read_mode       (read_mode)
    );

    assign reqv = {req_read_array, req_autoselect, req_program, req_block_erase,
                   req_chip_erase, req_protect, req_unprotect, req_suspend, req_resume};

    task automatic check(input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Drive one strobed write at a falling edge; outputs are sampled at the next falling edge.
    task automatic wr(input logic [1:0] ex, input logic [15:0] a, input logic [7:0] d);
        wr_stb     = 1'b1;
        exec_state = ex;
        wr_addr    = a;
        wr_data    = d;
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic idle_cycle();
        wr_stb = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("reset mode", 1, 32'(read_mode), 32'd0);
        check("reset requests", 1, 32'(reqv), 32'd0);

        for (int i = 0; i < NV; i++) begin
            wr(TBL[i].ex, TBL[i].a, TBL[i].d);
            check($sformatf("vector %0d requests", i), int'(TBL[i].tag), 32'(reqv), 32'(TBL[i].req));
            check($sformatf("vector %0d mode", i), int'(TBL[i].tag), 32'(read_mode), 32'(TBL[i].mode));
            if (TBL[i].req != '0) begin
                check($sformatf("vector %0d addr", i), int'(TBL[i].tag), 32'(req_addr), 32'(TBL[i].a));
                check($sformatf("vector %0d data", i), int'(TBL[i].tag), 32'(req_data), 32'(TBL[i].d));
            end
        end

        // R11 pulse width and hold of captured address and data
        wr(2'd0, 16'h0555, 8'hAA);
        wr(2'd0, 16'h0AAA, 8'h55);
        wr(2'd0, 16'h0555, 8'hA0);
        wr(2'd0, 16'hBEEF, 8'hC3);
        check("program pulse", 11, 32'(reqv), 32'h040);
        idle_cycle();
        check("pulse one cycle", 11, 32'(reqv), 32'h000);
        check("addr held", 11, 32'(req_addr), 32'hBEEF);
        check("data held", 11, 32'(req_data), 32'hC3);
        check("status held", 12, 32'(read_mode), 32'd2);

        // R1 reset discards a partial sequence and clears the mode
        wr(2'd0, 16'h0555, 8'hAA);
        wr(2'd0, 16'h0AAA, 8'h55);
        wr(2'd0, 16'h0555, 8'h90);
        check("asel before reset", 3, 32'(read_mode), 32'd1);
        wr(2'd0, 16'h0555, 8'hAA);
        rst = 1'b1;
        idle_cycle();
        rst = 1'b0;
        check("mode after reset", 1, 32'(read_mode), 32'd0);
        wr(2'd0, 16'h0AAA, 8'h55);
        check("no progress after reset", 1, 32'(reqv), 32'h000);
        wr(2'd0, 16'h0555, 8'h90);
        check("command after reset", 1, 32'(reqv), 32'h000);
        check("mode stays array", 1, 32'(read_mode), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule